// File: doc/BRIEF.md
# Legacy I/O Configuration Decoder

This block holds one byte of configuration for a legacy ISA peripheral cluster and turns it into address-decoded chip selects. The byte sits at a single fixed I/O address. The host writes it with the I/O write strobe and can read it back with the I/O read strobe. Its fields enable the floppy controller, place the parallel port, place two serial ports (A and B) in one of several arrangements, and enable the primary IDE channel.

The selects are combinational from the I/O address and the stored byte. The peripheral cores hang off these selects. For each serial port the block also reports which interrupt line the port should drive, together with a valid flag. The block does not contain the peripheral cores. A build-time parameter states whether an IDE channel exists at all.

Top module: `sio_cfg_decoder`

## Requirements
- R1: A write (io_wr high at address 0x3F3) stores io_wdata into the configuration byte at the clock edge. The decoded outputs reflect the new value from the following cycle onward.
- R2: A write strobe at any other address, such as 0x3F2, 0x7F3 or 0xB3F3, leaves the byte unchanged. So does an address of 0x3F3 with io_wr low. The same holds for the outputs decoded from it.
- R3: While io_rd is high and the address is 0x3F3, io_rdata equals the stored byte and io_rdata_oe is 1. At all other times io_rdata is 0 and io_rdata_oe is 0.
- R4: After reset the byte reads 0x9D. This decodes to: floppy on, parallel port at 0x378, serial A at 0x3F8, serial B at 0x2F8, IDE off.
- R5: When bit 0 is set, cs_fdc is high for addresses 0x3F0–0x3F7, with two exceptions. It is never high for 0x3F3. It is not high for 0x3F6 while IDE is active. When bit 0 is clear, cs_fdc is never high.
- R6: Bits 2:1 place the parallel port. 00 is off. 01 selects 0x3BC–0x3BE. 10 selects 0x378–0x37B. 11 selects 0x278–0x27B.
- R7: Bits 5:3 place the serial ports, each with an 8-byte window from its base:
  - 001: A at 0x3F8 only.
  - 010: B at 0x2F8 only.
  - 011: A at 0x3F8 and B at 0x2F8.
  - 100: A at 0x3E8 and B at 0x2E8.
  - 110: B at 0x3F8 only.
  - 111: A at 0x2F8 and B at 0x3F8.
  - 000 and 101: both off.
- R8: For an enabled serial port, the interrupt number is 4 if bit 8 of its base is set, and 3 otherwise. The valid flag is 1. For a disabled port, the valid flag is 0 and the number is 0.
- R9: With IDE_PRESENT=1 and bit 6 set, cs_ide_cmd is high for 0x1F0–0x1F7 and cs_ide_ctl is high for 0x3F6. Otherwise, and always with IDE_PRESENT=0, both stay low.
- R10: At most one chip select is high for any address and configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, zero when not driven |
| io_rdata_oe | output | 1 | Read data is being driven |
| cs_fdc | output | 1 | Floppy controller select |
| cs_lpt | output | 1 | Parallel port select |
| cs_uart_a | output | 1 | Serial port A select |
| cs_uart_b | output | 1 | Serial port B select |
| cs_ide_cmd | output | 1 | IDE command block select |
| cs_ide_ctl | output | 1 | IDE control port select |
| uart_a_irq | output | 4 | Serial A interrupt number |
| uart_a_irq_vld | output | 1 | Serial A interrupt number valid |
| uart_b_irq | output | 4 | Serial B interrupt number |
| uart_b_irq_vld | output | 1 | Serial B interrupt number valid |

## Verification
The hardest case to reach is the shared address 0x3F6. It moves between the floppy and IDE selects only when bit 0 and bit 6 take particular values together. It also behaves differently on a build with no IDE channel. The swapped serial arrangement, where port A takes the secondary base and its interrupt flips, is similarly rare. To reach all of these, every one of the 256 configuration values is written in turn into two instances, one with IDE and one without. After each write, the full 10-bit address space plus upper-bit aliases is swept, and every select and interrupt output is compared with an arithmetic model.

// File: rtl/sio_cfg_pkg.sv
`timescale 1ns/1ps
package sio_cfg_pkg;
   localparam int ISA_AW = 16;

   // field positions inside the configuration byte
   localparam int FDC_BIT  = 0;
   localparam int LPT_LSB  = 1;
   localparam int UART_LSB = 3;
   localparam int IDE_BIT  = 6;

   // bit of a serial base that steers it to the primary interrupt
   localparam int UART_PRI_ADDR_BIT = 8;

   localparam logic [ISA_AW-1:0] FDC_BASE     = 16'h03F0;
   localparam logic [ISA_AW-1:0] IDE_CMD_BASE = 16'h01F0;
   localparam logic [ISA_AW-1:0] IDE_CTL_ADDR = 16'h03F6;

   localparam logic [ISA_AW-1:0] LPT_MONO = 16'h03BC;
   localparam logic [ISA_AW-1:0] LPT_PRI  = 16'h0378;
   localparam logic [ISA_AW-1:0] LPT_SEC  = 16'h0278;

   localparam logic [ISA_AW-1:0] COM_3F8 = 16'h03F8;
   localparam logic [ISA_AW-1:0] COM_2F8 = 16'h02F8;
   localparam logic [ISA_AW-1:0] COM_3E8 = 16'h03E8;
   localparam logic [ISA_AW-1:0] COM_2E8 = 16'h02E8;

   typedef enum logic [1:0] {
      LPT_OFF    = 2'b00,
      LPT_AT_3BC = 2'b01,
      LPT_AT_378 = 2'b10,
      LPT_AT_278 = 2'b11
   } lpt_sel_e;

   typedef enum logic [2:0] {
      UART_NONE0   = 3'b000,
      UART_A_ONLY  = 3'b001,
      UART_B_ONLY  = 3'b010,
      UART_BOTH    = 3'b011,
      UART_ALT     = 3'b100,
      UART_NONE5   = 3'b101,
      UART_B_AT_1  = 3'b110,
      UART_SWAPPED = 3'b111
   } uart_sel_e;
endpackage

// File: rtl/sio_win_match.sv
`timescale 1ns/1ps
module sio_win_match #(
   parameter int ADDR_W = 16,
   parameter int SPAN_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [SPAN_W-1:0] span,
   input  logic              en,
   output logic              hit
);
   if (SPAN_W >= ADDR_W) begin : g_bad_span
      $error("sio_win_match: SPAN_W must be narrower than ADDR_W");
   end

   logic [ADDR_W-1:0] offset;

   assign offset = addr - base;
   assign hit    = en && (addr >= base) && (offset < ADDR_W'(span));
endmodule

// File: rtl/sio_cfg_reg.sv
`timescale 1ns/1ps
module sio_cfg_reg
   import sio_cfg_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                DATA_W    = 8,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 16'h03F3,
   parameter logic [DATA_W-1:0] RESET_VAL = 8'h9D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rdata_oe,
   output logic              fdc_en,
   output logic [1:0]        lpt_sel,
   output logic [2:0]        uart_sel,
   output logic              ide_req
);
   if (DATA_W != 8) begin : g_bad_data
      $error("sio_cfg_reg: configuration byte must be 8 bits");
   end

   logic              addr_hit;
   logic [DATA_W-1:0] cfg_r;

   assign addr_hit = (io_addr == CFG_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_r <= RESET_VAL;
      else if (io_wr && addr_hit)
         cfg_r <= io_wdata;
   end

   assign io_rdata_oe = io_rd && addr_hit;
   assign io_rdata    = io_rdata_oe ? cfg_r : '0;

   assign fdc_en   = cfg_r[FDC_BIT];
   assign lpt_sel  = cfg_r[LPT_LSB +: 2];
   assign uart_sel = cfg_r[UART_LSB +: 3];
   assign ide_req  = cfg_r[IDE_BIT];

   assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && (io_addr == CFG_ADDR)) |=> (cfg_r == $past(io_wdata)));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(io_wr && (io_addr == CFG_ADDR)) |=> $stable(cfg_r));

   assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (!io_rdata_oe && (io_rdata == '0)));

   assert_reset_val_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cfg_r == RESET_VAL));
endmodule

// File: rtl/sio_lpt_map.sv
`timescale 1ns/1ps
module sio_lpt_map
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic [1:0]        lpt_sel,
   output logic              cs_lpt
);
   localparam int SPAN_W    = 3;
   localparam int MONO_SPAN = 3;
   localparam int STD_SPAN  = 4;

   logic              win_en;
   logic [ADDR_W-1:0] win_base;
   logic [SPAN_W-1:0] win_span;

   always_comb begin
      win_en   = 1'b1;
      win_base = '0;
      win_span = SPAN_W'(STD_SPAN);
      unique case (lpt_sel_e'(lpt_sel))
         LPT_AT_3BC: begin
            win_base = ADDR_W'(LPT_MONO);
            win_span = SPAN_W'(MONO_SPAN);
         end
         LPT_AT_378: win_base = ADDR_W'(LPT_PRI);
         LPT_AT_278: win_base = ADDR_W'(LPT_SEC);
         default: begin
            win_en   = 1'b0;
            win_span = '0;
         end
      endcase
   end

   sio_win_match #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_lpt_win (
      .addr (io_addr),
      .base (win_base),
      .span (win_span),
      .en   (win_en),
      .hit  (cs_lpt)
   );

   assert_lpt_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (lpt_sel == 2'b00) |-> !cs_lpt);

   assert_lpt_mono_top_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((lpt_sel == 2'b01) && (io_addr == ADDR_W'(16'h03BF))) |-> !cs_lpt);
endmodule

// File: rtl/sio_uart_map.sv
`timescale 1ns/1ps
module sio_uart_map
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W  = 16,
   parameter int IRQ_W   = 4,
   parameter int IRQ_PRI = 4,
   parameter int IRQ_SEC = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           io_addr,
   input  logic [2:0]                  uart_sel,
   output logic [1:0]                  cs_uart,
   output logic [1:0][IRQ_W-1:0]       irq_num,
   output logic [1:0]                  irq_vld
);
   localparam int NPORT   = 2;
   localparam int SPAN_W  = 4;
   localparam int WIN_LEN = 8;

   if (IRQ_PRI >= (1 << IRQ_W) || IRQ_SEC >= (1 << IRQ_W)) begin : g_bad_irq
      $error("sio_uart_map: interrupt numbers do not fit IRQ_W");
   end
   if (IRQ_PRI == 0 || IRQ_SEC == 0 || IRQ_PRI == IRQ_SEC) begin : g_bad_irq_val
      $error("sio_uart_map: interrupt numbers must be distinct and nonzero");
   end

   logic [NPORT-1:0]             port_en;
   logic [NPORT-1:0][ADDR_W-1:0] port_base;

   always_comb begin
      port_en   = '0;
      port_base = '0;
      unique case (uart_sel_e'(uart_sel))
         UART_A_ONLY: begin
            port_en[0] = 1'b1; port_base[0] = ADDR_W'(COM_3F8);
         end
         UART_B_ONLY: begin
            port_en[1] = 1'b1; port_base[1] = ADDR_W'(COM_2F8);
         end
         UART_BOTH: begin
            port_en    = 2'b11;
            port_base[0] = ADDR_W'(COM_3F8);
            port_base[1] = ADDR_W'(COM_2F8);
         end
         UART_ALT: begin
            port_en    = 2'b11;
            port_base[0] = ADDR_W'(COM_3E8);
            port_base[1] = ADDR_W'(COM_2E8);
         end
         UART_B_AT_1: begin
            port_en[1] = 1'b1; port_base[1] = ADDR_W'(COM_3F8);
         end
         UART_SWAPPED: begin
            port_en    = 2'b11;
            port_base[0] = ADDR_W'(COM_2F8);
            port_base[1] = ADDR_W'(COM_3F8);
         end
         default: port_en = '0;
      endcase
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      sio_win_match #(.ADDR_W(ADDR_W), .SPAN_W(SPAN_W)) u_win (
         .addr (io_addr),
         .base (port_base[p]),
         .span (SPAN_W'(WIN_LEN)),
         .en   (port_en[p]),
         .hit  (cs_uart[p])
      );

      always_comb begin
         if (!port_en[p])
            irq_num[p] = '0;
         else if (port_base[p][UART_PRI_ADDR_BIT])
            irq_num[p] = IRQ_W'(IRQ_PRI);
         else
            irq_num[p] = IRQ_W'(IRQ_SEC);
      end
      assign irq_vld[p] = port_en[p];

      assert_irq_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq_vld[p] |-> ((irq_num[p] == IRQ_W'(IRQ_PRI)) || (irq_num[p] == IRQ_W'(IRQ_SEC))));

      assert_irq_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_vld[p] |-> ((irq_num[p] == '0) && !cs_uart[p]));
   end

   assert_uart_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cs_uart));
endmodule

// File: rtl/sio_cfg_decoder.sv
`timescale 1ns/1ps
module sio_cfg_decoder
   import sio_cfg_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int IRQ_W       = 4,
   parameter int IRQ_PRI     = 4,
   parameter int IRQ_SEC     = 3,
   parameter bit IDE_PRESENT = 1'b1,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 16'h03F3,
   parameter logic [DATA_W-1:0] RESET_VAL = 8'h9D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   output logic [DATA_W-1:0] io_rdata,
   output logic              io_rdata_oe,
   output logic              cs_fdc,
   output logic              cs_lpt,
   output logic              cs_uart_a,
   output logic              cs_uart_b,
   output logic              cs_ide_cmd,
   output logic              cs_ide_ctl,
   output logic [IRQ_W-1:0]  uart_a_irq,
   output logic              uart_a_irq_vld,
   output logic [IRQ_W-1:0]  uart_b_irq,
   output logic              uart_b_irq_vld
);
   localparam int FDC_LEN_LOG = 3;
   localparam logic [ADDR_W-1:0] FDC_BASE_W = ADDR_W'(FDC_BASE);
   localparam logic [ADDR_W-1:0] IDE_CTL_W  = ADDR_W'(IDE_CTL_ADDR);
   localparam logic [FDC_LEN_LOG-1:0] CFG_OFF = CFG_ADDR[FDC_LEN_LOG-1:0];
   localparam logic [FDC_LEN_LOG-1:0] CTL_OFF = IDE_CTL_W[FDC_LEN_LOG-1:0];

   if (ADDR_W < 12) begin : g_bad_addr
      $error("sio_cfg_decoder: ADDR_W must cover the 12-bit legacy I/O space");
   end

   logic                  fdc_en;
   logic [1:0]            lpt_sel;
   logic [2:0]            uart_sel;
   logic                  ide_req;
   logic                  ide_on;
   logic                  fdc_range;
   logic [FDC_LEN_LOG-1:0] fdc_off;
   logic [1:0]            uart_cs;
   logic [1:0][IRQ_W-1:0] uart_irq;
   logic [1:0]            uart_vld;

   sio_cfg_reg #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CFG_ADDR  (CFG_ADDR),
      .RESET_VAL (RESET_VAL)
   ) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .io_addr     (io_addr),
      .io_rd       (io_rd),
      .io_wr       (io_wr),
      .io_wdata    (io_wdata),
      .io_rdata    (io_rdata),
      .io_rdata_oe (io_rdata_oe),
      .fdc_en      (fdc_en),
      .lpt_sel     (lpt_sel),
      .uart_sel    (uart_sel),
      .ide_req     (ide_req)
   );

   assign ide_on = IDE_PRESENT ? ide_req : 1'b0;

   // floppy block: eight bytes, minus the config byte and the shared control port
   assign fdc_range = (io_addr[ADDR_W-1:FDC_LEN_LOG] == FDC_BASE_W[ADDR_W-1:FDC_LEN_LOG]);
   assign fdc_off   = io_addr[FDC_LEN_LOG-1:0];
   assign cs_fdc    = fdc_en && fdc_range && (fdc_off != CFG_OFF)
                      && !(ide_on && (fdc_off == CTL_OFF));

   sio_lpt_map #(.ADDR_W(ADDR_W)) u_lpt (
      .clk     (clk),
      .rst_n   (rst_n),
      .io_addr (io_addr),
      .lpt_sel (lpt_sel),
      .cs_lpt  (cs_lpt)
   );

   sio_uart_map #(
      .ADDR_W  (ADDR_W),
      .IRQ_W   (IRQ_W),
      .IRQ_PRI (IRQ_PRI),
      .IRQ_SEC (IRQ_SEC)
   ) u_uart (
      .clk      (clk),
      .rst_n    (rst_n),
      .io_addr  (io_addr),
      .uart_sel (uart_sel),
      .cs_uart  (uart_cs),
      .irq_num  (uart_irq),
      .irq_vld  (uart_vld)
   );

   assign cs_uart_a      = uart_cs[0];
   assign cs_uart_b      = uart_cs[1];
   assign uart_a_irq     = uart_irq[0];
   assign uart_b_irq     = uart_irq[1];
   assign uart_a_irq_vld = uart_vld[0];
   assign uart_b_irq_vld = uart_vld[1];

   if (IDE_PRESENT) begin : g_ide
      sio_win_match #(.ADDR_W(ADDR_W), .SPAN_W(4)) u_ide_cmd (
         .addr (io_addr),
         .base (ADDR_W'(IDE_CMD_BASE)),
         .span (4'd8),
         .en   (ide_on),
         .hit  (cs_ide_cmd)
      );
      assign cs_ide_ctl = ide_on && (io_addr == IDE_CTL_W);
   end else begin : g_no_ide
      assign cs_ide_cmd = 1'b0;
      assign cs_ide_ctl = 1'b0;
   end

   assert_fdc_cfg_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == CFG_ADDR) |-> !cs_fdc);

   assert_fdc_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fdc |-> (io_rdata == '0 || io_rd) && fdc_en);

   assert_ide_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_ide_cmd || cs_ide_ctl) |-> ide_req);

   assert_single_select_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_fdc, cs_lpt, cs_uart_a, cs_uart_b, cs_ide_cmd, cs_ide_ctl}));
endmodule

// File: tb/sio_cfg_decoder_bench.sv
`timescale 1ns/1ps
module sio_cfg_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] io_addr;
   logic        io_rd, io_wr;
   logic [7:0]  io_wdata;

   logic [7:0] rd_y, rd_n;
   logic       oe_y, oe_n;
   logic       fdc_y, lpt_y, ua_y, ub_y, icmd_y, ictl_y, av_y, bv_y;
   logic       fdc_n, lpt_n, ua_n, ub_n, icmd_n, ictl_n, av_n, bv_n;
   logic [3:0] ai_y, bi_y, ai_n, bi_n;

   int  vectors = 0;
   int  miscompares = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   sio_cfg_decoder u_sio_cfg_decoder (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(rd_y), .io_rdata_oe(oe_y),
      .cs_fdc(fdc_y), .cs_lpt(lpt_y), .cs_uart_a(ua_y), .cs_uart_b(ub_y),
      .cs_ide_cmd(icmd_y), .cs_ide_ctl(ictl_y),
      .uart_a_irq(ai_y), .uart_a_irq_vld(av_y), .uart_b_irq(bi_y), .uart_b_irq_vld(bv_y)
   );

   sio_cfg_decoder #(.IDE_PRESENT(1'b0)) u_sio_cfg_decoder_noide (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(rd_n), .io_rdata_oe(oe_n),
      .cs_fdc(fdc_n), .cs_lpt(lpt_n), .cs_uart_a(ua_n), .cs_uart_b(ub_n),
      .cs_ide_cmd(icmd_n), .cs_ide_ctl(ictl_n),
      .uart_a_irq(ai_n), .uart_a_irq_vld(av_n), .uart_b_irq(bi_n), .uart_b_irq_vld(bv_n)
   );

   task automatic chk(input string tag, input int act, input int exp,
                      input logic [7:0] c, input logic [15:0] a);
      vectors++;
      if (act != exp) begin
         miscompares++;
         $display("FAIL %s cfg=%02h addr=%04h actual=%0d expected=%0d", tag, c, a, act, exp);
      end
   endtask

   // ---- arithmetic model ----
   function automatic bit in_win(input int a, input int b, input int n);
      return (b != 0) && (a >= b) && (a < b + n);
   endfunction

   function automatic int base_a(input logic [7:0] c);
      case (c[5:3])
         3'd1, 3'd3: return 'h3F8;
         3'd4:       return 'h3E8;
         3'd7:       return 'h2F8;
         default:    return 0;
      endcase
   endfunction

   function automatic int base_b(input logic [7:0] c);
      case (c[5:3])
         3'd2, 3'd3: return 'h2F8;
         3'd4:       return 'h2E8;
         3'd6, 3'd7: return 'h3F8;
         default:    return 0;
      endcase
   endfunction

   function automatic int irq_of(input int b);
      if (b == 0) return 0;
      return ((b / 256) % 2 == 1) ? 4 : 3;
   endfunction

   function automatic bit m_lpt(input logic [7:0] c, input int a);
      case (c[2:1])
         2'd1:    return in_win(a, 'h3BC, 3);
         2'd2:    return in_win(a, 'h378, 4);
         2'd3:    return in_win(a, 'h278, 4);
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit m_fdc(input logic [7:0] c, input int a, input bit ide);
      return c[0] && in_win(a, 'h3F0, 8) && (a != 'h3F3) && !(ide && c[6] && a == 'h3F6);
   endfunction

   task automatic check_sel(input logic [7:0] c, input logic [15:0] a);
      int ai;
      bit e_fdc_y, e_fdc_n, e_lpt, e_ua, e_ub, e_icmd, e_ictl;
      ai      = int'(a);
      e_fdc_y = m_fdc(c, ai, 1'b1);
      e_fdc_n = m_fdc(c, ai, 1'b0);
      e_lpt   = m_lpt(c, ai);
      e_ua    = in_win(ai, base_a(c), 8);
      e_ub    = in_win(ai, base_b(c), 8);
      e_icmd  = c[6] && in_win(ai, 'h1F0, 8);
      e_ictl  = c[6] && (ai == 'h3F6);
      chk("R5 cs_fdc", int'(fdc_y), int'(e_fdc_y), c, a);
      chk("R5 cs_fdc noide", int'(fdc_n), int'(e_fdc_n), c, a);
      chk("R6 cs_lpt", int'(lpt_y), int'(e_lpt), c, a);
      chk("R6 cs_lpt noide", int'(lpt_n), int'(e_lpt), c, a);
      chk("R7 cs_uart_a", int'(ua_y), int'(e_ua), c, a);
      chk("R7 cs_uart_b", int'(ub_y), int'(e_ub), c, a);
      chk("R7 cs_uart_a noide", int'(ua_n), int'(e_ua), c, a);
      chk("R7 cs_uart_b noide", int'(ub_n), int'(e_ub), c, a);
      chk("R9 cs_ide_cmd", int'(icmd_y), int'(e_icmd), c, a);
      chk("R9 cs_ide_ctl", int'(ictl_y), int'(e_ictl), c, a);
      chk("R9 noide cmd/ctl", int'(icmd_n) + int'(ictl_n), 0, c, a);
      chk("R10 select count",
          $countones({fdc_y, lpt_y, ua_y, ub_y, icmd_y, ictl_y}),
          int'(e_fdc_y) + int'(e_lpt) + int'(e_ua) + int'(e_ub) + int'(e_icmd) + int'(e_ictl), c, a);
   endtask

   task automatic check_irq(input logic [7:0] c);
      int ba, bb;
      ba = base_a(c);
      bb = base_b(c);
      chk("R8 uart_a_irq", int'(ai_y), irq_of(ba), c, 16'h0);
      chk("R8 uart_a_irq_vld", int'(av_y), int'(ba != 0), c, 16'h0);
      chk("R8 uart_b_irq", int'(bi_y), irq_of(bb), c, 16'h0);
      chk("R8 uart_b_irq_vld", int'(bv_y), int'(bb != 0), c, 16'h0);
      chk("R8 uart_a_irq noide", int'(ai_n), irq_of(ba), c, 16'h0);
      chk("R8 uart_b_irq noide", int'(bi_n), irq_of(bb), c, 16'h0);
   endtask

   task automatic sweep(input logic [7:0] c);
      for (int i = 0; i < 1028; i++) begin
         logic [15:0] a;
         case (i)
            1024:    a = 16'h13F3;
            1025:    a = 16'h83F8;
            1026:    a = 16'h07F6;
            1027:    a = 16'h41F0;
            default: a = 16'(i);
         endcase
         io_addr = a;
         #1;
         check_sel(c, a);
      end
      check_irq(c);
      io_addr = 16'h0;
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic strobe);
      @(negedge clk);
      io_addr  = a;
      io_wdata = d;
      io_wr    = strobe;
      @(negedge clk);
      io_wr    = 1'b0;
      io_addr  = 16'h0;
   endtask

   task automatic rd_check(input string tag, input logic [7:0] exp);
      @(negedge clk);
      io_addr = 16'h03F3;
      io_rd   = 1'b1;
      #1;
      chk({tag, " readback"}, int'(rd_y), int'(exp), exp, io_addr);
      chk({tag, " readback noide"}, int'(rd_n), int'(exp), exp, io_addr);
      chk("R3 oe during read", int'(oe_y) + int'(oe_n), 2, exp, io_addr);
      io_addr = 16'h03F2;
      #1;
      chk("R3 wrong address read", int'(rd_y) + int'(oe_y), 0, exp, io_addr);
      io_rd   = 1'b0;
      io_addr = 16'h03F3;
      #1;
      chk("R3 no strobe", int'(rd_y) + int'(oe_y) + int'(rd_n), 0, exp, io_addr);
      io_addr = 16'h0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL R1 watchdog actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      io_addr  = 16'h0;
      io_rd    = 1'b0;
      io_wr    = 1'b0;
      io_wdata = 8'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R4: reset value and its decoded meaning
      rd_check("R4", 8'h9D);
      io_addr = 16'h03F0; #1; chk("R4 floppy on", int'(fdc_y), 1, 8'h9D, io_addr);
      io_addr = 16'h0378; #1; chk("R4 lpt at 378", int'(lpt_y), 1, 8'h9D, io_addr);
      io_addr = 16'h03F8; #1; chk("R4 uart a at 3F8", int'(ua_y), 1, 8'h9D, io_addr);
      io_addr = 16'h02F8; #1; chk("R4 uart b at 2F8", int'(ub_y), 1, 8'h9D, io_addr);
      io_addr = 16'h01F0; #1; chk("R4 ide off", int'(icmd_y), 0, 8'h9D, io_addr);
      sweep(8'h9D);

      // R1: every configuration value, swept over the address space
      for (int c = 0; c < 256; c++) begin
         wr(16'h03F3, 8'(c), 1'b1);
         sweep(8'(c));
         rd_check("R1", 8'(c));
      end

      // R2: writes that must be ignored
      wr(16'h03F3, 8'h55, 1'b1);
      wr(16'h03F2, 8'hAA, 1'b1);
      wr(16'h07F3, 8'hAA, 1'b1);
      wr(16'hB3F3, 8'hAA, 1'b1);
      wr(16'h03F3, 8'hAA, 1'b0);
      rd_check("R2", 8'h55);
      io_addr = 16'h02F8; #1; chk("R2 uart b kept", int'(ub_y), 1, 8'h55, io_addr);
      io_addr = 16'h03BC; #1; chk("R2 lpt kept off", int'(lpt_y), 0, 8'h55, io_addr);
      io_addr = 16'h03F0; #1; chk("R2 floppy kept", int'(fdc_y), 1, 8'h55, io_addr);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule